// File: doc/BRIEF.md
# PCI Outbound Memory Window Translator

This block sits between a system bus and a PCI host bridge. It decides whether a system address falls in one of three fixed memory windows, and it converts that address into a 32-bit PCI memory address. Each window has a 32-bit map register that software can write. The register sets where in PCI space the window lands. Software reaches the map registers through a small register port, and every write is used at once.

A parameter picks one of two board layouts. The layouts differ in the window system bases, the window sizes and how the map register is read. In layout A (`VARIANT = 0`) the low nibble of the map register becomes PCI address bits 31:28. In layout B (`VARIANT = 1`) the map register bits at or above the window size are kept and become the high PCI address bits. A request is a single-cycle strobe carrying an address. The result (valid, hit, window index, PCI address) is registered and appears one cycle later.

Top module: `pci_mem_window_xlat`

## Requirements
- R1: An address inside window i gives `xl_hit`=1 and `xl_win`=i, where window i covers [sys_base_i, sys_base_i + size_i). An address outside all three windows gives `xl_hit`=0, `xl_win`=0 and `xl_pci_addr`=0.
- R2: Layout A uses these windows: window 0 is 0x44000000 with size 0x0C000000, window 1 is 0x50000000 with size 0x10000000, and window 2 is 0x60000000 with size 0x10000000. The PCI address is ({map_i[3:0], 28'h0} + (addr − sys_base_i)) mod 2^32.
- R3: Layout B uses these windows: window 0 is 0x63000000 with size 0x01000000, window 1 is 0x64000000 with size 0x04000000, and window 2 is 0x68000000 with size 0x08000000. The PCI address is ((map_i & ~(size_i − 1)) + (addr − sys_base_i)) mod 2^32.
- R4: A request presented with `xl_req`=1 at one clock edge produces its result, with `xl_valid`=1, after that edge. In any cycle after a clock edge with no request, `xl_valid`, `xl_hit`, `xl_win` and `xl_pci_addr` are all zero.
- R5: Map register i sits at byte offset MAP_OFS + 4·i (default MAP_OFS = 0x10, so 0x10, 0x14 and 0x18). A write stores all 32 bits. `rg_rdata` returns the stored value combinationally. Any other offset, misaligned ones included, reads as 0, and writes to it change no map register.
- R6: A request in the same cycle as a write to the map register of the window it hits is translated with the newly written value.
- R7: While reset is held, and right after reset, all map registers read 0 and all result outputs are 0.
- R8: The first and last byte of each window hit that window. Because the windows are contiguous, the byte after window i's last byte hits window i+1. The byte below window 0 and the byte after window 2 miss.
- R9: Map bits that the formula of the active layout does not use have no effect on the PCI address. In layout A these are bits 31:4. In layout B these are the bits below the window size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rg_wr | input | 1 | Register write strobe, one cycle |
| rg_addr | input | REG_AW | Register byte offset |
| rg_wdata | input | 32 | Register write data |
| rg_rdata | output | 32 | Register read data, combinational on rg_addr |
| xl_req | input | 1 | Translation request strobe |
| xl_addr | input | 32 | System address to translate |
| xl_valid | output | 1 | Result valid, one cycle after the request |
| xl_hit | output | 1 | Address fell in a window |
| xl_win | output | 2 | Index of the window hit |
| xl_pci_addr | output | 32 | Translated PCI memory address |

## Verification
Both layouts are instantiated side by side on the same stimulus. Each is checked against a model built from the formulas above.

- Map values with set bits outside the used field tell a correct masking apart from a plain copy of the register. In layout A these bits are the high ones; in layout B they are the low ones.
- Addresses at the first byte, last byte and one past the last byte of each window separate off-by-one range compares, and show whether neighbouring windows are picked correctly.
- Back-to-back requests, idle gaps and a write in the same cycle as a request show the one-cycle latency, the clearing of the outputs when idle and the write bypass.
- Writes to offsets next to the map registers show that decoding is exact.

// File: rtl/pci_xlat_pkg.sv
package pci_xlat_pkg;

    typedef logic [31:0] word_t;

    localparam int NUM_WIN = 3;
    localparam int WIN_IW  = 2;

    typedef struct packed {
        logic             vld;
        logic             hit;
        logic [WIN_IW-1:0] win;
        word_t            addr;
    } xlat_res_t;

    // System-side base of window idx for the chosen board layout
    function automatic word_t win_sys_base(input int variant, input int idx);
        word_t b;
        if (variant == 0) begin
            case (idx)
                0:       b = 32'h4400_0000;
                1:       b = 32'h5000_0000;
                default: b = 32'h6000_0000;
            endcase
        end else begin
            case (idx)
                0:       b = 32'h6300_0000;
                1:       b = 32'h6400_0000;
                default: b = 32'h6800_0000;
            endcase
        end
        return b;
    endfunction

    // Byte size of window idx for the chosen board layout
    function automatic word_t win_size(input int variant, input int idx);
        word_t s;
        if (variant == 0) begin
            case (idx)
                0:       s = 32'h0C00_0000;
                1:       s = 32'h1000_0000;
                default: s = 32'h1000_0000;
            endcase
        end else begin
            case (idx)
                0:       s = 32'h0100_0000;
                1:       s = 32'h0400_0000;
                default: s = 32'h0800_0000;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/map_regfile.sv
module map_regfile
    import pci_xlat_pkg::*;
#(
    parameter int              N_WIN   = NUM_WIN,
    parameter int              REG_AW  = 8,
    parameter logic [REG_AW-1:0] MAP_OFS = 8'h10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rg_wr,
    input  logic [REG_AW-1:0]       rg_addr,
    input  word_t                   rg_wdata,
    output word_t                   rg_rdata,
    output logic [N_WIN-1:0]        wr_sel,
    output logic [N_WIN-1:0][31:0]  map_q,
    output logic [N_WIN-1:0][31:0]  map_eff
);

    localparam int IDX_W = REG_AW - 2;

    typedef struct packed {
        logic [N_WIN-1:0][31:0] map;
    } regs_t;

    regs_t             st_d, st_q;
    logic [REG_AW-1:0] rel_ofs;
    logic              in_range;
    logic [IDX_W-1:0]  word_idx;
    logic [N_WIN-1:0]  addr_sel;

    // Offset decode: aligned word inside the map block
    always_comb begin
        rel_ofs  = rg_addr - MAP_OFS;
        word_idx = rel_ofs[REG_AW-1:2];
        in_range = (rg_addr >= MAP_OFS) && (rel_ofs[1:0] == 2'b00)
                   && (int'(word_idx) < N_WIN);
        addr_sel = '0;
        for (int i = 0; i < N_WIN; i++) begin
            addr_sel[i] = in_range && (int'(word_idx) == i);
        end
    end

    always_comb begin
        st_d   = st_q;
        wr_sel = addr_sel & {N_WIN{rg_wr}};
        for (int i = 0; i < N_WIN; i++) begin
            if (wr_sel[i]) begin
                st_d.map[i] = rg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read mux over stored values
    always_comb begin
        rg_rdata = '0;
        for (int i = 0; i < N_WIN; i++) begin
            if (addr_sel[i]) begin
                rg_rdata = st_q.map[i];
            end
        end
    end

    // Same-cycle write forwarding toward the translators
    generate
        for (genvar g = 0; g < N_WIN; g++) begin : g_fwd
            assign map_eff[g] = wr_sel[g] ? rg_wdata : st_q.map[g];
        end
    endgenerate

    assign map_q = st_q.map;

endmodule

// File: rtl/win_match.sv
module win_match
    import pci_xlat_pkg::*;
#(
    parameter int VARIANT = 0,
    parameter int IDX     = 0
) (
    input  word_t sys_addr,
    input  word_t map_val,
    output logic  hit,
    output word_t pci_addr
);

    localparam word_t SYS_BASE = win_sys_base(VARIANT, IDX);
    localparam word_t SIZE     = win_size(VARIANT, IDX);
    localparam word_t KEEP     = ~(SIZE - 32'd1);

    word_t offset;
    word_t pci_base;

    // Windows are at most 2^28 bytes, so a wrapped difference below the
    // base always exceeds the size and a single compare suffices.
    assign offset = sys_addr - SYS_BASE;
    assign hit    = (offset < SIZE);

    generate
        if (VARIANT == 0) begin : g_nibble
            assign pci_base = map_val << 28;
        end else begin : g_masked
            assign pci_base = map_val & KEEP;
        end
    endgenerate

    assign pci_addr = pci_base + offset;

endmodule

// File: rtl/pci_mem_window_xlat.sv
module pci_mem_window_xlat
    import pci_xlat_pkg::*;
#(
    parameter int                VARIANT = 0,
    parameter int                REG_AW  = 8,
    parameter logic [REG_AW-1:0] MAP_OFS = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rg_wr,
    input  logic [REG_AW-1:0] rg_addr,
    input  logic [31:0]       rg_wdata,
    output logic [31:0]       rg_rdata,
    input  logic              xl_req,
    input  logic [31:0]       xl_addr,
    output logic              xl_valid,
    output logic              xl_hit,
    output logic [1:0]        xl_win,
    output logic [31:0]       xl_pci_addr
);

    logic [NUM_WIN-1:0]       wr_sel;
    logic [NUM_WIN-1:0][31:0] map_q;
    logic [NUM_WIN-1:0][31:0] map_eff;
    logic [NUM_WIN-1:0]       win_hit;
    logic [NUM_WIN-1:0][31:0] win_pci;

    xlat_res_t res_d, res_q;

    map_regfile #(
        .N_WIN  (NUM_WIN),
        .REG_AW (REG_AW),
        .MAP_OFS(MAP_OFS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rg_wr   (rg_wr),
        .rg_addr (rg_addr),
        .rg_wdata(rg_wdata),
        .rg_rdata(rg_rdata),
        .wr_sel  (wr_sel),
        .map_q   (map_q),
        .map_eff (map_eff)
    );

    generate
        for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
            win_match #(
                .VARIANT(VARIANT),
                .IDX    (g)
            ) u_match (
                .sys_addr(xl_addr),
                .map_val (map_eff[g]),
                .hit     (win_hit[g]),
                .pci_addr(win_pci[g])
            );
        end
    endgenerate

    always_comb begin
        res_d     = '0;
        res_d.vld = xl_req;
        if (xl_req) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (win_hit[i]) begin
                    res_d.hit  = 1'b1;
                    res_d.win  = WIN_IW'(i);
                    res_d.addr = win_pci[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign xl_valid    = res_q.vld;
    assign xl_hit      = res_q.hit;
    assign xl_win      = res_q.win;
    assign xl_pci_addr = res_q.addr;

endmodule

// File: rtl/pci_xlat_chk.sv
module pci_xlat_chk
    import pci_xlat_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    xl_req,
    input logic [31:0]             rg_wdata,
    input logic                    xl_valid,
    input logic                    xl_hit,
    input logic [1:0]              xl_win,
    input logic [31:0]             xl_pci_addr,
    input logic [NUM_WIN-1:0]      win_hit,
    input logic [NUM_WIN-1:0]      wr_sel,
    input logic [NUM_WIN-1:0][31:0] map_q
);

    assert_req_gives_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req |=> xl_valid);

    assert_idle_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_req |=> (!xl_valid && !xl_hit && xl_win == 2'd0 && xl_pci_addr == 32'd0));

    assert_miss_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid && !xl_hit) |-> (xl_pci_addr == 32'd0 && xl_win == 2'd0));

    assert_one_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_hit));

    assert_win_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit |-> (xl_win < 2'd3));

    assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    generate
        for (genvar g = 0; g < NUM_WIN; g++) begin : g_wr
            assert_write_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
                wr_sel[g] |=> (map_q[g] == $past(rg_wdata)));
        end
    endgenerate

endmodule

bind pci_mem_window_xlat pci_xlat_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xl_req     (xl_req),
    .rg_wdata   (rg_wdata),
    .xl_valid   (xl_valid),
    .xl_hit     (xl_hit),
    .xl_win     (xl_win),
    .xl_pci_addr(xl_pci_addr),
    .win_hit    (win_hit),
    .wr_sel     (wr_sel),
    .map_q      (map_q)
);

// File: tb/tb_pci_mem_window_xlat.sv
module tb_pci_mem_window_xlat;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rg_wr = 1'b0;
    logic [7:0]  rg_addr = 8'h00;
    logic [31:0] rg_wdata = '0;
    logic        xl_req = 1'b0;
    logic [31:0] xl_addr = '0;

    logic [31:0] rd_a, rd_b;
    logic        v_a, h_a, v_b, h_b;
    logic [1:0]  w_a, w_b;
    logic [31:0] p_a, p_b;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mdl_map [3];

    always #5 clk = ~clk;

    pci_mem_window_xlat #(.VARIANT(0)) dut (
        .clk(clk), .rst_n(rst_n), .rg_wr(rg_wr), .rg_addr(rg_addr),
        .rg_wdata(rg_wdata), .rg_rdata(rd_a), .xl_req(xl_req), .xl_addr(xl_addr),
        .xl_valid(v_a), .xl_hit(h_a), .xl_win(w_a), .xl_pci_addr(p_a));

    pci_mem_window_xlat #(.VARIANT(1)) dut_b (
        .clk(clk), .rst_n(rst_n), .rg_wr(rg_wr), .rg_addr(rg_addr),
        .rg_wdata(rg_wdata), .rg_rdata(rd_b), .xl_req(xl_req), .xl_addr(xl_addr),
        .xl_valid(v_b), .xl_hit(h_b), .xl_win(w_b), .xl_pci_addr(p_b));

    function automatic logic [31:0] t_base(int v, int i);
        logic [31:0] ba [3] = '{32'h4400_0000, 32'h5000_0000, 32'h6000_0000};
        logic [31:0] bb [3] = '{32'h6300_0000, 32'h6400_0000, 32'h6800_0000};
        return (v == 0) ? ba[i] : bb[i];
    endfunction

    function automatic logic [31:0] t_size(int v, int i);
        logic [31:0] sa [3] = '{32'h0C00_0000, 32'h1000_0000, 32'h1000_0000};
        logic [31:0] sb [3] = '{32'h0100_0000, 32'h0400_0000, 32'h0800_0000};
        return (v == 0) ? sa[i] : sb[i];
    endfunction

    // {valid, hit, win[1:0], pci[31:0]}
    function automatic logic [35:0] model(int v, logic [31:0] a);
        logic [35:0] r = {1'b1, 35'd0};
        for (int i = 0; i < 3; i++) begin
            logic [31:0] bs = t_base(v, i);
            logic [31:0] sz = t_size(v, i);
            logic [31:0] pb;
            if (a >= bs && (a - bs) < sz) begin
                pb = (v == 0) ? {mdl_map[i][3:0], 28'h0} : (mdl_map[i] & ~(sz - 32'd1));
                r = {1'b1, 1'b1, 2'(i), pb + (a - bs)};
            end
        end
        return r;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_res(string tag, logic [31:0] a);
        check({tag, " layoutA"}, {28'd0, v_a, h_a, w_a, p_a}, {28'd0, model(0, a)});
        check({tag, " layoutB"}, {28'd0, v_b, h_b, w_b, p_b}, {28'd0, model(1, a)});
    endtask

    task automatic wr_reg(logic [7:0] ofs, logic [31:0] d);
        @(negedge clk);
        rg_wr = 1'b1; rg_addr = ofs; rg_wdata = d;
        @(negedge clk);
        rg_wr = 1'b0;
        if (ofs == 8'h10) mdl_map[0] = d;
        if (ofs == 8'h14) mdl_map[1] = d;
        if (ofs == 8'h18) mdl_map[2] = d;
    endtask

    task automatic rd_check(string tag, logic [7:0] ofs, logic [31:0] exp);
        rg_addr = ofs;
        #1;
        check({tag, " rdA"}, {32'd0, rd_a}, {32'd0, exp});
        check({tag, " rdB"}, {32'd0, rd_b}, {32'd0, exp});
    endtask

    task automatic xlate(string tag, logic [31:0] a);
        @(negedge clk);
        xl_req = 1'b1; xl_addr = a;
        @(negedge clk);
        xl_req = 1'b0;
        check_res(tag, a);
    endtask

    task automatic t_reset();
        check("R7 out A", {60'd0, v_a, h_a, w_a} | {32'd0, p_a}, 64'd0);
        check("R7 out B", {60'd0, v_b, h_b, w_b} | {32'd0, p_b}, 64'd0);
        rd_check("R7 map0", 8'h10, 32'd0);
        rd_check("R7 map1", 8'h14, 32'd0);
        rd_check("R7 map2", 8'h18, 32'd0);
        xlate("R7 zero map win1", 32'h6500_1234);
    endtask

    task automatic t_regs();
        wr_reg(8'h10, 32'hDEAD_BEE3);
        wr_reg(8'h14, 32'h1234_5678);
        wr_reg(8'h18, 32'hFFFF_FFF5);
        rd_check("R5 map0", 8'h10, 32'hDEAD_BEE3);
        rd_check("R5 map1", 8'h14, 32'h1234_5678);
        rd_check("R5 map2", 8'h18, 32'hFFFF_FFF5);
        wr_reg(8'h1C, 32'hAAAA_AAAA);
        wr_reg(8'h11, 32'h5555_5555);
        wr_reg(8'h0C, 32'h7777_7777);
        rd_check("R5 unmapped 1C", 8'h1C, 32'd0);
        rd_check("R5 misaligned 11", 8'h11, 32'd0);
        rd_check("R5 map0 kept", 8'h10, 32'hDEAD_BEE3);
        rd_check("R5 map1 kept", 8'h14, 32'h1234_5678);
        rd_check("R5 map2 kept", 8'h18, 32'hFFFF_FFF5);
    endtask

    task automatic t_xlat();
        xlate("R2 R3 A-win0", 32'h4512_3456);
        xlate("R2 R3 A-win1", 32'h5ABC_DEF0);
        xlate("R2 R3 A-win2 wrap", 32'h6F00_0010);
        xlate("R2 R3 B-win0", 32'h6380_0004);
        xlate("R2 R3 B-win1", 32'h6612_3450);
        xlate("R2 R3 B-win2", 32'h6C00_0100);
        wr_reg(8'h14, 32'h0000_0002);
        xlate("R2 R3 small map win1", 32'h5000_0040);
        xlate("R2 R3 small map B win1", 32'h6400_0040);
    endtask

    task automatic t_bounds();
        for (int v = 0; v < 2; v++) begin
            xlate("R8 below win0", t_base(v, 0) - 32'd1);
            for (int i = 0; i < 3; i++) begin
                xlate("R8 first byte", t_base(v, i));
                xlate("R8 last byte", t_base(v, i) + t_size(v, i) - 32'd1);
            end
            xlate("R8 past win2", t_base(v, 2) + t_size(v, 2));
        end
        xlate("R1 addr 0", 32'h0000_0000);
        xlate("R1 addr max", 32'hFFFF_FFFF);
    endtask

    task automatic t_ignored();
        wr_reg(8'h10, 32'h0000_0001);
        xlate("R9 ref win0 A", 32'h4400_0100);
        xlate("R9 ref win0 B", 32'h6300_0100);
        wr_reg(8'h10, 32'hFFF0_0001);
        xlate("R9 high bits A", 32'h4400_0100);
        wr_reg(8'h10, 32'h2AFF_FFFF);
        xlate("R9 low bits B", 32'h6300_0100);
        xlate("R9 low bits A", 32'h4400_0100);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        rg_wr = 1'b1; rg_addr = 8'h14; rg_wdata = 32'hC7C0_0003;
        xl_req = 1'b1; xl_addr = 32'h5000_0800;
        mdl_map[1] = 32'hC7C0_0003;
        @(negedge clk);
        rg_wr = 1'b0; xl_req = 1'b0;
        check_res("R6 bypass A", 32'h5000_0800);
        @(negedge clk);
        rg_wr = 1'b1; rg_addr = 8'h18; rg_wdata = 32'h9000_0000;
        xl_req = 1'b1; xl_addr = 32'h6900_0020;
        mdl_map[2] = 32'h9000_0000;
        @(negedge clk);
        rg_wr = 1'b0; xl_req = 1'b0;
        check_res("R6 bypass B", 32'h6900_0020);
    endtask

    task automatic t_stream();
        logic [31:0] seq [6] = '{32'h4800_0000, 32'h6400_0004, 32'h1000_0000,
                                 32'h6300_00FC, 32'h6FFF_FFFC, 32'h5555_0000};
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k > 0) check_res("R4 back-to-back", seq[k-1]);
            xl_req = 1'b1; xl_addr = seq[k];
        end
        @(negedge clk);
        check_res("R4 back-to-back last", seq[5]);
        xl_req = 1'b0; xl_addr = 32'h4400_0000;
        @(negedge clk);
        check("R4 idle A", {28'd0, v_a, h_a, w_a, p_a}, 64'd0);
        check("R4 idle B", {28'd0, v_b, h_b, w_b, p_b}, 64'd0);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) mdl_map[i] = 32'd0;
        repeat (3) @(negedge clk);
        t_reset_held();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_xlat();
        t_bounds();
        t_ignored();
        t_same_cycle();
        t_stream();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    task automatic t_reset_held();
        check("R7 held A", {28'd0, v_a, h_a, w_a, p_a}, 64'd0);
        check("R7 held B", {28'd0, v_b, h_b, w_b, p_b}, 64'd0);
    endtask

endmodule